// File: doc/BRIEF.md
# Prescaled Up-Counting Timer with Update Interrupt

This block is a general-purpose up-counter that sits on a simple word-addressed register port. A programmable divider turns the input clock into count ticks. The counter climbs until it matches a programmable reload value. On the tick that finds it there, it wraps to zero and produces an update event. That event can latch a status flag and emit a one-cycle interrupt pulse. Software can read and write the count, the divider and the reload value at any time. It can also force the count back to zero with a one-shot event command.

The register port is a plain single-cycle access and has no back-pressure. A write is taken on the rising edge where `wr_en` is high. A read is combinational from `addr`, so `rd_data` is valid in the same cycle. Several slots exist only as storage that software can read and write: capture/compare settings, DMA settings and option settings. Nothing inside the timer uses them. The address is a word index. Slot numbers are given in the requirements below.

Top module: `utmr_top`

## Requirements
- R1: After reset every register reads zero, including control (slot 0), interrupt enable (slot 3), status (slot 4), count (slot 9), divider (slot 10) and reload (slot 11), and `irq` is low.
- R2: While control slot 0 bit 0 is set, the count advances once every (divider + 1) clock edges. While that bit is clear, the count and the divider phase hold.
- R3: When a tick finds the count equal to a non-zero reload value, the count becomes zero on that tick and an update event occurs in the same cycle. Below the reload value, the count simply increments.
- R4: With reload slot 11 equal to zero, no update event occurs: the status flag stays clear, `irq` stays low, and the count runs freely.
- R5: An update event sets status slot 4 bit 0 and drives `irq` high for exactly the following cycle, but only if interrupt-enable slot 3 bit 0 is set.
- R6: A write to status slot 4 ANDs the written value into the flags. Writing 0 to bit 0 clears it and writing 1 keeps it. On a collision, a same-cycle update wins over the clear.
- R7: Writing event slot 5 with bit 0 set forces the count and the divider phase to zero; with bit 0 clear it has no effect. Slot 5 always reads zero.
- R8: Writing count slot 9 loads the low 16 bits of the written value as the count and restarts the divider phase at zero.
- R9: Writing divider slot 10 leaves the count value unchanged; only later tick spacing follows the new value.
- R10: Plain storage slots 0, 1, 2, 3, 6, 7, 8, 13 to 16 and 18 to 20 return the last full 32-bit value written.
- R11: Slots 12, 17 and 21 to 31 are unmapped: writes there change nothing, and reads there return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Word index of the register slot |
| wr_en | input | 1 | Write strobe, taken on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | One-cycle update interrupt pulse |

## Verification
The hardest state to reach from the ports is a divider caught partway through its period at the moment a count write or an event command lands. Only that case shows whether the divider phase restarts. The stimulus counts enabled edges exactly: it enables the counter, waits a fixed number of edges, and disables it again. This leaves the divider at a known non-zero phase. It then issues the write and runs a window too short for a tick from a fresh phase, but long enough for one from the stale phase. The same edge counting places the count one tick below the reload value, so the wrap tick and its single interrupt pulse can be isolated.

// File: rtl/utmr_pkg.sv
package utmr_pkg;

  localparam int SLOT_W = 5;
  localparam int NSLOT  = 1 << SLOT_W;

  typedef enum logic [SLOT_W-1:0] {
    SL_CTRL1  = 5'd0,
    SL_CTRL2  = 5'd1,
    SL_SLAVE  = 5'd2,
    SL_IEN    = 5'd3,
    SL_STAT   = 5'd4,
    SL_EVGEN  = 5'd5,
    SL_CMODE1 = 5'd6,
    SL_CMODE2 = 5'd7,
    SL_CENA   = 5'd8,
    SL_COUNT  = 5'd9,
    SL_DIV    = 5'd10,
    SL_RELOAD = 5'd11,
    SL_CMP1   = 5'd13,
    SL_CMP2   = 5'd14,
    SL_CMP3   = 5'd15,
    SL_CMP4   = 5'd16,
    SL_DMACFG = 5'd18,
    SL_DMAWIN = 5'd19,
    SL_OPT    = 5'd20
  } slot_e;

  // Slots held as pure software storage
  function automatic logic is_plain(int unsigned idx);
    case (idx)
      0, 1, 2, 3, 6, 7, 8, 13, 14, 15, 16, 18, 19, 20: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Slots that hold state of any kind (event slot counts: it has an effect)
  function automatic logic is_mapped(int unsigned idx);
    return is_plain(idx) || idx == 4 || idx == 5 || idx == 9 ||
           idx == 10 || idx == 11;
  endfunction

endpackage

// File: rtl/utmr_regs.sv
module utmr_regs import utmr_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] plain_rd,
  output logic              run_o,
  output logic              ien_o
);

  logic [DATA_W-1:0] slot_val [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    if (is_plain(g)) begin : g_store
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                q <= '0;
        else if (wr_en && addr == SLOT_W'(g))      q <= wr_data;
      end
      assign slot_val[g] = q;
    end else begin : g_hole
      assign slot_val[g] = '0;
    end
  end

  assign plain_rd = slot_val[addr];
  assign run_o    = slot_val[SL_CTRL1][0];
  assign ien_o    = slot_val[SL_IEN][0];

endmodule

// File: rtl/utmr_prescale.sv
module utmr_prescale #(
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] div_i,
  output logic             tick_o
);

  logic [PSC_W-1:0] phase_q;
  logic             at_lim;

  // ">=" so a divider lowered below the current phase ticks at once
  assign at_lim = phase_q >= div_i;
  assign tick_o = run_i && at_lim && !restart_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         phase_q <= '0;
    else if (restart_i) phase_q <= '0;
    else if (run_i)     phase_q <= at_lim ? '0 : phase_q + 1'b1;
  end

endmodule

// File: rtl/utmr_counter.sv
module utmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             ld_i,
  input  logic [CNT_W-1:0] ld_val_i,
  input  logic             clr_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             hit;

  assign hit   = (reload_i != '0) && (cnt_q == reload_i);
  assign upd_o = tick_i && hit;
  assign cnt_o = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= hit ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/utmr_top.sv
module utmr_top import utmr_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);

  logic              wr_cnt, wr_ug, wr_div, wr_rel, wr_stat;
  logic [DATA_W-1:0] plain_rd;
  logic              run, ien, tick, upd, restart;
  logic [PSC_W-1:0]  div_q;
  logic [CNT_W-1:0]  reload_q, cnt_q;
  logic              stat_q, irq_q;

  assign wr_cnt  = wr_en && (addr == SL_COUNT);
  assign wr_ug   = wr_en && (addr == SL_EVGEN) && wr_data[0];
  assign wr_div  = wr_en && (addr == SL_DIV);
  assign wr_rel  = wr_en && (addr == SL_RELOAD);
  assign wr_stat = wr_en && (addr == SL_STAT);
  assign restart = wr_cnt || wr_ug;

  utmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .plain_rd(plain_rd), .run_o(run), .ien_o(ien)
  );

  utmr_prescale #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst_n(rst_n), .run_i(run), .restart_i(restart),
    .div_i(div_q), .tick_o(tick)
  );

  utmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .ld_i(wr_cnt),
    .ld_val_i(wr_data[CNT_W-1:0]), .clr_i(wr_ug), .reload_i(reload_q),
    .cnt_o(cnt_q), .upd_o(upd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q    <= '0;
      reload_q <= '0;
      stat_q   <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      if (wr_div) div_q    <= wr_data[PSC_W-1:0];
      if (wr_rel) reload_q <= wr_data[CNT_W-1:0];
      // AND-mask clear; a same-cycle update sets the flag regardless
      stat_q <= (wr_stat ? (stat_q & wr_data[0]) : stat_q) | (upd && ien);
      irq_q  <= upd && ien;
    end
  end

  assign irq = irq_q;

  always_comb begin
    rd_data = plain_rd;
    case (addr)
      SL_STAT:   rd_data = DATA_W'(stat_q);
      SL_COUNT:  rd_data = DATA_W'(cnt_q);
      SL_DIV:    rd_data = DATA_W'(div_q);
      SL_RELOAD: rd_data = DATA_W'(reload_q);
      default:   ;
    endcase
  end

endmodule

// File: rtl/utmr_chk.sv
module utmr_chk import utmr_pkg::*; #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [SLOT_W-1:0] addr,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic              run,
  input logic              stat_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  reload_q
);

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R5
  irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat_q);

  // R4
  zero_reload_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(reload_q) == '0) |-> !irq);

  // R7
  ug_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SL_EVGEN && wr_data[0]) |=> cnt_q == '0);

  // R8
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SL_COUNT) |=> cnt_q == $past(wr_data[CNT_W-1:0]));

  // R9
  div_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SL_DIV && !run) |=> $stable(cnt_q));

  // R11
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!is_mapped(addr) || addr == SL_EVGEN) |-> rd_data == '0);

endmodule

bind utmr_top utmr_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .irq(irq), .run(run), .stat_q(stat_q), .cnt_q(cnt_q),
  .reload_q(reload_q)
);

// File: tb/sim_utmr_top.sv
module sim_utmr_top;
  import utmr_pkg::*;

  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [SLOT_W-1:0] a;
    logic [31:0]       exp;
    string             tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  int irq_seen = 0;
  bit reported = 1'b0;
  item_t sbq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  utmr_top u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
  );

  always @(negedge clk) if (irq === 1'b1) irq_seen++;

  // Monitor: pops each expected read result and compares it
  initial begin
    item_t it;
    forever begin
      wait (sbq.size() != 0);
      it = sbq.pop_front();
      n_tests++;
      if (rd_data !== it.exp) begin
        n_fail++;
        $display("FAIL %s slot %0d actual %h expected %h", it.tag, it.a, rd_data, it.exp);
      end
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  // Driver: presents the address and pushes the expected value
  task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); addr = a; wr_en = 1'b0; #1;
    it.a = a; it.exp = e; it.tag = tag;
    sbq.push_back(it);
  endtask

  // Counter enabled for exactly n sampled edges
  task automatic run_for(input int n);
    wr(SL_CTRL1, 32'd1);
    repeat (n - 2) @(negedge clk);
    wr(SL_CTRL1, 32'd0);
  endtask

  task automatic irq_chk(input int base, input int delta, input string tag);
    @(negedge clk); #1;
    n_tests++;
    if (irq_seen - base != delta) begin
      n_fail++;
      $display("FAIL %s irq pulses actual %0d expected %0d", tag, irq_seen - base, delta);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual running expected done");
    report();
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(SL_CTRL1, 0, "R1"); rd_chk(SL_IEN, 0, "R1"); rd_chk(SL_STAT, 0, "R1");
    rd_chk(SL_COUNT, 0, "R1"); rd_chk(SL_DIV, 0, "R1"); rd_chk(SL_RELOAD, 0, "R1");
    rd_chk(SL_CMP1, 0, "R1");
    irq_chk(irq_seen, 0, "R1");

    // R10 plain storage
    wr(SL_CMP3, 32'hA5A5_1234); wr(SL_OPT, 32'h0000_BEEF); wr(SL_DMAWIN, 32'hFFFF_0001);
    rd_chk(SL_CMP3, 32'hA5A5_1234, "R10"); rd_chk(SL_OPT, 32'h0000_BEEF, "R10");
    rd_chk(SL_DMAWIN, 32'hFFFF_0001, "R10");

    // R11 unmapped slots
    wr(5'd12, 32'hFFFF_FFFF); wr(5'd25, 32'h1); wr(5'd17, 32'h1);
    rd_chk(5'd12, 0, "R11"); rd_chk(5'd25, 0, "R11"); rd_chk(5'd31, 0, "R11");
    rd_chk(SL_CMP3, 32'hA5A5_1234, "R11"); rd_chk(SL_COUNT, 0, "R11");
    rd_chk(SL_CTRL1, 0, "R11");

    // R7 event slot reads zero
    wr(SL_EVGEN, 32'h3);
    rd_chk(SL_EVGEN, 0, "R7");

    // R2 divide by 4: 40 enabled edges give 10 ticks
    wr(SL_DIV, 32'd3); wr(SL_COUNT, 32'd0);
    run_for(40);
    rd_chk(SL_COUNT, 32'd10, "R2");

    // R9 divider rewrite keeps count
    wr(SL_DIV, 32'd0);
    rd_chk(SL_COUNT, 32'd10, "R9");
    run_for(10);
    rd_chk(SL_COUNT, 32'd20, "R9");

    // R3 R5 reload 5: wrap every 6 ticks, interrupts enabled
    wr(SL_RELOAD, 32'd5); wr(SL_COUNT, 32'd0); wr(SL_IEN, 32'd1);
    base = irq_seen;
    run_for(12);
    rd_chk(SL_COUNT, 0, "R3"); rd_chk(SL_STAT, 1, "R5");
    irq_chk(base, 2, "R5");

    // R6 AND-mask status write
    wr(SL_STAT, 32'h1);
    rd_chk(SL_STAT, 1, "R6");
    wr(SL_STAT, 32'hFFFF_FFFE);
    rd_chk(SL_STAT, 0, "R6");

    // R3 wrap exactly on the tick at the reload value
    base = irq_seen;
    run_for(4);
    rd_chk(SL_COUNT, 32'd4, "R3"); rd_chk(SL_STAT, 0, "R3");
    irq_chk(base, 0, "R3");
    run_for(2);
    rd_chk(SL_COUNT, 0, "R3"); rd_chk(SL_STAT, 1, "R3");
    irq_chk(base, 1, "R5");
    wr(SL_STAT, 32'h0);

    // R5 interrupt enable clear blocks flag and pulse
    wr(SL_IEN, 32'd0);
    base = irq_seen;
    run_for(6);
    rd_chk(SL_COUNT, 0, "R5"); rd_chk(SL_STAT, 0, "R5");
    irq_chk(base, 0, "R5");

    // R4 reload zero: free running, no update
    wr(SL_IEN, 32'd1); wr(SL_RELOAD, 32'd0); wr(SL_COUNT, 32'd0);
    base = irq_seen;
    run_for(12);
    rd_chk(SL_COUNT, 32'd12, "R4"); rd_chk(SL_STAT, 0, "R4");
    irq_chk(base, 0, "R4");

    // R8 count load, low 16 bits
    wr(SL_COUNT, 32'h0000_1234);
    rd_chk(SL_COUNT, 32'h1234, "R8");
    wr(SL_COUNT, 32'hABCD_0007);
    rd_chk(SL_COUNT, 32'h7, "R8");

    // R7 bit 0 clear does nothing, bit 0 set zeroes
    wr(SL_EVGEN, 32'h2);
    rd_chk(SL_COUNT, 32'h7, "R7");
    wr(SL_EVGEN, 32'h1);
    rd_chk(SL_COUNT, 0, "R7");

    // R8 count write restarts divider phase (phase left at 2)
    wr(SL_DIV, 32'd3); wr(SL_COUNT, 32'd0);
    run_for(6);
    rd_chk(SL_COUNT, 32'd1, "R8");
    wr(SL_COUNT, 32'd0);
    run_for(3);
    rd_chk(SL_COUNT, 0, "R8");

    // R7 event command restarts divider phase too
    wr(SL_COUNT, 32'd0);
    run_for(6);
    wr(SL_EVGEN, 32'h1);
    run_for(3);
    rd_chk(SL_COUNT, 0, "R7");

    wait (sbq.size() == 0);
    #2;
    report();
    $finish;
  end

endmodule